// File: doc/BRIEF.md
# Sideband Message Record Deserializer

This block listens to a narrow received-message sideband and turns each message into one wide parallel record. While a strobe is high, one byte arrives per clock along with a 5-bit message type code. The strobe stays high for a number of cycles that depends on the type. Every message is followed by at least one cycle with the strobe low, so a low strobe always ends a message.

From the byte stream, the block rebuilds the following fields:
- the type code;
- a 16-bit requester ID, with the bus number in the high byte and the device/function number in the low byte;
- a 16-bit vendor ID;
- a 32-bit payload, which for latency-reporting messages holds the snoop latency in bits [15:0] and the no-snoop latency in bits [31:16];
- a flag that says whether any payload byte was captured.

The record is loaded into output registers when the strobe falls, and a one-cycle done pulse marks it. A length-error flag is loaded with the record when the number of beats does not fit the type, or when the type code is reserved. The record and the flag then hold until the next done pulse.

Top module: `msg_record_deser`

## Requirements
- R1: After a synchronous active-high reset, rec_done, rec_len_err, rec_has_data and every record field read zero.
- R2: rec_done is high for exactly one cycle. That cycle is the one after the first low-strobe cycle that follows a message.
- R3: rec_type is the type code seen on the first beat. rec_req_id is {beat 1 byte, beat 2 byte}, and its low byte is zero for a 1-beat message.
- R4: For type 15, beats 3 to 6 fill rec_payload bytes 0 to 3 in order (bits [7:0] first). rec_has_data is set and rec_vendor_id is zero.
- R5: For type 16, beats 3 and 4 form rec_payload[15:0] (the snoop latency, low byte first). Beats 5 and 6 form rec_payload[31:16] (the no-snoop latency, low byte first).
- R6: For types 19 and 20, beats 3 and 4 form rec_vendor_id, low byte first. A 4-beat message leaves rec_payload zero and rec_has_data clear.
- R7: For types 19 and 20, beats 5 to 8 fill rec_payload bytes 0 to 3 in order, and rec_has_data is set.
- R8: For types 0 to 14 and 18, a 2-beat message gives rec_len_err low, rec_has_data clear, rec_payload zero and rec_vendor_id zero.
- R9: rec_len_err is high when the beat count does not fit the type. Types 0 to 14 and 18 need exactly 2 beats, types 15 and 16 need exactly 6, and types 19 and 20 need 4 or 8.
- R10: Types 17 and 21 to 31 always give rec_len_err high, whatever their length.
- R11: Beats after the 8th change no record field, and the message reports rec_len_err high.
- R12: Between done pulses, all record outputs and rec_len_err hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_vld | input | 1 | Message strobe, one byte per high cycle |
| msg_type | input | 5 | Message type code, valid while the strobe is high |
| msg_byte | input | 8 | Data byte of the current beat |
| rec_done | output | 1 | One-cycle pulse: a new record is on the outputs |
| rec_len_err | output | 1 | Beat count illegal for the type, or the type is reserved |
| rec_type | output | 5 | Type code of the record |
| rec_req_id | output | 16 | Requester ID {bus, device/function} |
| rec_vendor_id | output | 16 | Vendor ID of a vendor-defined message |
| rec_payload | output | 32 | Payload, or {no-snoop, snoop} latency |
| rec_has_data | output | 1 | At least one payload byte was captured |

## Verification
All 32 type codes are sent with lengths of 2, 4, 6 and 8 beats and random bytes. This shows which lengths each type accepts and whether each beat lands in the right field: a mis-steered beat shows up as a wrong byte in a different lane. Messages of 1, 9 and 11 beats test the short header case and the rule that beats after the 8th are ignored. Gaps of one, two and three idle cycles, including 1-beat messages separated by a single idle cycle, test the done timing and show that the record holds between messages.

// File: rtl/msgrec_pkg.sv
package msgrec_pkg;
  localparam int TYPE_W  = 5;
  localparam int BYTE_W  = 8;
  localparam int ID_W    = 16;
  localparam int PAY_W   = 32;

  localparam logic [TYPE_W-1:0] T_LAST_SHORT = 5'd14;
  localparam logic [TYPE_W-1:0] T_SLOT_PWR   = 5'd15;
  localparam logic [TYPE_W-1:0] T_LAT_RPT    = 5'd16;
  localparam logic [TYPE_W-1:0] T_UNLOCK     = 5'd18;
  localparam logic [TYPE_W-1:0] T_VEND0      = 5'd19;
  localparam logic [TYPE_W-1:0] T_VEND1      = 5'd20;

  typedef enum logic [1:0] {
    CLS_SHORT,
    CLS_PAY,
    CLS_VEND,
    CLS_RSVD
  } msg_cls_e;

  typedef struct packed {
    logic [TYPE_W-1:0] mtype;
    logic [ID_W-1:0]   req_id;
    logic [ID_W-1:0]   vend_id;
    logic [PAY_W-1:0]  payload;
    logic              has_data;
  } rec_t;

  function automatic msg_cls_e classify(input logic [TYPE_W-1:0] t);
    if (t <= T_LAST_SHORT || t == T_UNLOCK) return CLS_SHORT;
    if (t == T_SLOT_PWR || t == T_LAT_RPT)  return CLS_PAY;
    if (t == T_VEND0 || t == T_VEND1)       return CLS_VEND;
    return CLS_RSVD;
  endfunction
endpackage

// File: rtl/msgrec_beat_ctr.sv
module msgrec_beat_ctr #(
  parameter int MAX_BEATS = 8,
  parameter int CNT_W     = $clog2(MAX_BEATS + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  output logic [CNT_W-1:0] cnt,
  output logic             first,
  output logic             fin
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_BEATS + 1);

  assign first = vld && (cnt == '0);
  assign fin   = !vld && (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (vld) begin
      if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
    end else              cnt <= '0;
  end

  // R11: the count saturates one past the longest legal message
  p_cnt_sat_r11: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_SAT && vld) |=> (cnt == CNT_SAT));
  // R2: a low strobe always leaves the counter at zero
  p_cnt_clear_r2: assert property (@(posedge clk) disable iff (rst)
    !vld |=> (cnt == '0));
endmodule

// File: rtl/msgrec_assemble.sv
module msgrec_assemble
  import msgrec_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld,
  input  logic              first,
  input  logic [CNT_W-1:0]  beat_idx,
  input  logic [TYPE_W-1:0] msg_type,
  input  logic [BYTE_W-1:0] msg_byte,
  output rec_t              work
);
  localparam int HDR_BYTES = ID_W / BYTE_W;
  localparam int VID_BYTES = ID_W / BYTE_W;
  localparam int PAY_BYTES = PAY_W / BYTE_W;
  localparam int VPAY_OFF  = HDR_BYTES + VID_BYTES;

  msg_cls_e         cls;
  logic             pay_wr, vid_wr;
  logic [CNT_W-1:0] pay_sel, vid_sel;

  assign cls = classify(work.mtype);

  always_comb begin
    pay_wr  = 1'b0;
    vid_wr  = 1'b0;
    pay_sel = '0;
    vid_sel = '0;
    if (vld && !first) begin
      if (cls == CLS_PAY && int'(beat_idx) >= HDR_BYTES &&
          int'(beat_idx) < HDR_BYTES + PAY_BYTES) begin
        pay_wr  = 1'b1;
        pay_sel = beat_idx - CNT_W'(HDR_BYTES);
      end
      if (cls == CLS_VEND && int'(beat_idx) >= HDR_BYTES &&
          int'(beat_idx) < VPAY_OFF) begin
        vid_wr  = 1'b1;
        vid_sel = beat_idx - CNT_W'(HDR_BYTES);
      end
      if (cls == CLS_VEND && int'(beat_idx) >= VPAY_OFF &&
          int'(beat_idx) < VPAY_OFF + PAY_BYTES) begin
        pay_wr  = 1'b1;
        pay_sel = beat_idx - CNT_W'(VPAY_OFF);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work.mtype    <= '0;
      work.req_id   <= '0;
      work.has_data <= 1'b0;
    end else if (first) begin
      work.mtype    <= msg_type;
      work.req_id   <= {msg_byte, {BYTE_W{1'b0}}};
      work.has_data <= 1'b0;
    end else if (vld) begin
      if (beat_idx == CNT_W'(1)) work.req_id[BYTE_W-1:0] <= msg_byte;
      if (pay_wr) work.has_data <= 1'b1;
    end
  end

  for (genvar g = 0; g < PAY_BYTES; g++) begin : g_pay_lane
    always_ff @(posedge clk) begin
      if (rst || first)                           work.payload[g*BYTE_W +: BYTE_W] <= '0;
      else if (pay_wr && pay_sel == CNT_W'(g))    work.payload[g*BYTE_W +: BYTE_W] <= msg_byte;
    end
  end

  for (genvar g = 0; g < VID_BYTES; g++) begin : g_vid_lane
    always_ff @(posedge clk) begin
      if (rst || first)                           work.vend_id[g*BYTE_W +: BYTE_W] <= '0;
      else if (vid_wr && vid_sel == CNT_W'(g))    work.vend_id[g*BYTE_W +: BYTE_W] <= msg_byte;
    end
  end

  // R3: the type is fixed by the first beat for the rest of the message
  p_type_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (vld && !first) |=> $stable(work.mtype));
  // R11: no field moves on beats past the last capturable one
  p_late_beat_r11: assert property (@(posedge clk) disable iff (rst)
    (vld && int'(beat_idx) >= VPAY_OFF + PAY_BYTES) |=> $stable(work));
endmodule

// File: rtl/msgrec_len_chk.sv
module msgrec_len_chk
  import msgrec_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int SHORT_LEN  = 2,
  parameter int PAY_LEN    = 6,
  parameter int VEND_SHORT = 4,
  parameter int VEND_LONG  = 8
) (
  input  logic [TYPE_W-1:0] mtype,
  input  logic [CNT_W-1:0]  beats,
  output logic              bad
);
  always_comb begin
    unique case (classify(mtype))
      CLS_SHORT: bad = (beats != CNT_W'(SHORT_LEN));
      CLS_PAY:   bad = (beats != CNT_W'(PAY_LEN));
      CLS_VEND:  bad = (beats != CNT_W'(VEND_SHORT)) && (beats != CNT_W'(VEND_LONG));
      default:   bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/msg_record_deser.sv
module msg_record_deser
  import msgrec_pkg::*;
#(
  parameter int MAX_BEATS = 8,
  parameter int CNT_W     = $clog2(MAX_BEATS + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_vld,
  input  logic [TYPE_W-1:0] msg_type,
  input  logic [BYTE_W-1:0] msg_byte,
  output logic              rec_done,
  output logic              rec_len_err,
  output logic [TYPE_W-1:0] rec_type,
  output logic [ID_W-1:0]   rec_req_id,
  output logic [ID_W-1:0]   rec_vendor_id,
  output logic [PAY_W-1:0]  rec_payload,
  output logic              rec_has_data
);
  logic [CNT_W-1:0] cnt;
  logic             first, fin, bad;
  rec_t             work, rec_q;

  msgrec_beat_ctr #(.MAX_BEATS(MAX_BEATS), .CNT_W(CNT_W)) i_ctr (
    .clk(clk), .rst(rst), .vld(msg_vld), .cnt(cnt), .first(first), .fin(fin)
  );

  msgrec_assemble #(.CNT_W(CNT_W)) i_asm (
    .clk(clk), .rst(rst), .vld(msg_vld), .first(first), .beat_idx(cnt),
    .msg_type(msg_type), .msg_byte(msg_byte), .work(work)
  );

  msgrec_len_chk #(.CNT_W(CNT_W), .VEND_LONG(MAX_BEATS)) i_len (
    .mtype(work.mtype), .beats(cnt), .bad(bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_q       <= '0;
      rec_len_err <= 1'b0;
      rec_done    <= 1'b0;
    end else begin
      rec_done <= fin;
      if (fin) begin
        rec_q       <= work;
        rec_len_err <= bad;
      end
    end
  end

  assign rec_type      = rec_q.mtype;
  assign rec_req_id    = rec_q.req_id;
  assign rec_vendor_id = rec_q.vend_id;
  assign rec_payload   = rec_q.payload;
  assign rec_has_data  = rec_q.has_data;

  // R2: end of message yields done next cycle, and done never lasts two cycles
  p_done_after_end_r2: assert property (@(posedge clk) disable iff (rst)
    fin |=> rec_done);
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    rec_done |=> !rec_done);
  // R12: outputs only move when a record is delivered
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !fin |=> ($stable(rec_q) && $stable(rec_len_err)));
  // R10: reserved codes always carry the error flag
  p_rsvd_err_r10: assert property (@(posedge clk) disable iff (rst)
    (rec_done && classify(rec_type) == CLS_RSVD) |-> rec_len_err);
  // R8: short-class records never claim data
  p_short_nodata_r8: assert property (@(posedge clk) disable iff (rst)
    (rec_done && classify(rec_type) == CLS_SHORT) |-> !rec_has_data);
endmodule

// File: tb/test_msg_record_deser.sv
`timescale 1ns/1ps
module test_msg_record_deser;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        msg_vld = 1'b0;
  logic [4:0]  msg_type = '0;
  logic [7:0]  msg_byte = '0;
  logic        rec_done, rec_len_err, rec_has_data;
  logic [4:0]  rec_type;
  logic [15:0] rec_req_id, rec_vendor_id;
  logic [31:0] rec_payload;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;
  bit  seen_msg = 0;

  always #2.5 clk = ~clk;

  msg_record_deser i_msg_record_deser (
    .clk(clk), .rst(rst), .msg_vld(msg_vld), .msg_type(msg_type), .msg_byte(msg_byte),
    .rec_done(rec_done), .rec_len_err(rec_len_err), .rec_type(rec_type),
    .rec_req_id(rec_req_id), .rec_vendor_id(rec_vendor_id),
    .rec_payload(rec_payload), .rec_has_data(rec_has_data)
  );

  // reference model: collect bytes in a queue, build the record when the strobe drops
  int          q[$];
  int          cur_t;
  int          e_len = 0;
  logic        e_done = 0, e_err = 0, e_hd = 0;
  logic [4:0]  e_type = 0;
  logic [15:0] e_req = 0, e_vid = 0;
  logic [31:0] e_pay = 0;

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      e_done <= 0; e_err <= 0; e_hd <= 0; e_type <= 0;
      e_req <= 0; e_vid <= 0; e_pay <= 0; e_len <= 0;
    end else begin
      e_done <= 0;
      if (msg_vld) begin
        if (q.size() == 0) cur_t = int'(msg_type);
        q.push_back(int'(msg_byte));
      end else if (q.size() > 0) begin
        int n;
        logic [15:0] r, v;
        logic [31:0] p;
        logic h, ok;
        n = q.size();
        r = {q[0][7:0], (n > 1) ? q[1][7:0] : 8'h00};
        v = 0; p = 0; h = 0;
        for (int k = 2; k < n && k < 8; k++) begin
          if ((cur_t == 15 || cur_t == 16) && k <= 5) begin
            p[8*(k-2) +: 8] = q[k][7:0]; h = 1;
          end
          if (cur_t == 19 || cur_t == 20) begin
            if (k <= 3) v[8*(k-2) +: 8] = q[k][7:0];
            else begin p[8*(k-4) +: 8] = q[k][7:0]; h = 1; end
          end
        end
        if (cur_t <= 14 || cur_t == 18)      ok = (n == 2);
        else if (cur_t == 15 || cur_t == 16) ok = (n == 6);
        else if (cur_t == 19 || cur_t == 20) ok = (n == 4 || n == 8);
        else                                 ok = 0;
        e_done <= 1; e_type <= 5'(cur_t); e_req <= r; e_vid <= v;
        e_pay <= p; e_hd <= h; e_err <= !ok; e_len <= n;
        q.delete();
      end
    end
  end

  task automatic chk(input string tag, input string fld, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, fld, act, exp, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      string tg, tp, tv, te, th;
      int t;
      t = int'(e_type);
      if (!seen_msg)     tg = "R1";
      else if (!e_done)  tg = "R12";
      else               tg = "";
      tp = (t == 15) ? "R4" : (t == 16) ? "R5" : (t == 19 || t == 20) ? "R7" :
           (t <= 14 || t == 18) ? "R8" : "R3";
      tv = (t == 19 || t == 20) ? "R6" : (t == 15) ? "R4" : "R8";
      th = (t == 19 || t == 20) ? ((e_len == 8) ? "R7" : "R6") : (t == 15) ? "R4" : "R8";
      te = (t == 17 || t > 20) ? "R10" : (t <= 14 || t == 18) ? ((e_len == 2) ? "R8" : "R9") : "R9";
      if (e_len > 8) begin tp = "R11"; te = "R11"; tv = "R11"; end
      if (tg != "") begin tp = tg; tv = tg; te = tg; th = tg; end
      chk((tg == "R1") ? "R1" : "R2", "done", 32'(rec_done), 32'(e_done));
      chk((tg != "") ? tg : "R3", "type", 32'(rec_type), 32'(e_type));
      chk((tg != "") ? tg : "R3", "req_id", 32'(rec_req_id), 32'(e_req));
      chk(tv, "vendor_id", 32'(rec_vendor_id), 32'(e_vid));
      chk(tp, "payload", rec_payload, e_pay);
      chk(th, "has_data", 32'(rec_has_data), 32'(e_hd));
      chk(te, "len_err", 32'(rec_len_err), 32'(e_err));
      if (e_done) seen_msg = 1;
    end
  end

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(posedge clk); #1;
      msg_vld = 0; msg_byte = 8'h00;
    end
  endtask

  task automatic send(input int t, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      msg_vld = 1; msg_type = 5'(t); msg_byte = 8'($urandom);
    end
    @(posedge clk); #1;
    msg_vld = 0; msg_type = 5'($urandom); msg_byte = 8'($urandom);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    idle(3);
    for (int t = 0; t < 32; t++) begin
      send(t, 2); idle(t % 3);
      send(t, 4); idle(1);
      send(t, 6); idle(2);
      send(t, 8); idle(t % 2);
    end
    for (int t = 0; t < 32; t += 3) begin
      send(t, 1);
      send(t, 9); idle(1);
      send(t, 11);
      send(19, 1);
    end
    send(20, 8); send(16, 6); send(15, 5); send(19, 3); idle(1);
    rst = 1; idle(2); rst = 0; seen_msg = 0; idle(3);
    send(16, 6); idle(3);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule